// File: doc/BRIEF.md
# Pack/Unpack Swizzle Index Sequencer

This block drives the element addressing of a vectorised swizzle move. After a start pulse it latches a vector length, a source subvector length, a destination subvector length (each 1 to 4), two loop-order flags and a four-lane selector immediate. It then produces one move per cycle. Each move carries a source element index, a destination element index and the decoded meaning of the selector for that destination lane: a source read, a constant zero, a constant one, or a skip.

A destination walker and a source walker advance together. By default both walk element-outer and subvector-inner. The `pack_en` flag flips the source to subvector-outer order. The `unpack_en` flag flips the destination, which also sets the order in which moves are issued. In vertical-first mode the moves come in groups, and the sequencer stops after each group until the next external step. The group size depends on which flags are set.

The controller has four states. ST_IDLE goes to ST_MOVE on start with a non-zero length, and to ST_FINI on start with a zero length. ST_MOVE goes to ST_FINI after the final move. In vertical-first mode ST_MOVE goes to ST_PAUSE after the last move of a group. ST_PAUSE returns to ST_MOVE on `next_step`, and ST_FINI returns to ST_IDLE on `next_step`.

Top module: `swz_pu_seq`

## Requirements
- R1: After reset the block is in its idle state with `mv_valid`, `wr_en` and `done` low.
- R2: Without either order flag, moves are issued element-outer, lane-inner. The destination index is i*DST + j, and the source index is i*SRC + lane, where i is the element, j the destination lane, and DST and SRC the lengths (a length is its 2-bit code plus one).
- R3: With `pack_en` set, the source index is lane*VL + i, and the issue order is unchanged.
- R4: With `unpack_en` set, moves are issued lane-outer, element-inner, and the destination index is j*VL + i.
- R5: Both flags set together is legal: the issue order follows R4 and the source index follows R3.
- R6: The selector for destination lane j sits at `swiz[3j+2:3j]`. Codes 0 and 7 skip the lane (write and read low). Code 1 writes constant zero and code 2 writes constant one (write high, `const_valid` high, read low, `const_one` high only for code 2). Codes 3 to 6 read source lanes 0 to 3 (read and write high). `src_idx` is 0 whenever no read is made. A lane that is skipped or constant still uses a destination step.
- R7: A selector that names a source lane at or beyond the source length acts as a skip.
- R8: In horizontal mode, VL*DST consecutive moves are issued. Then `done` stays high until `next_step`, after which the block is idle.
- R9: In vertical-first mode the group size is SRC by default, DST when only `pack_en` is set, and 1 when both flags are set. `done` is raised after each group and after the final, possibly shorter, group. `next_step` resumes the moves.
- R10: A start with a vector length of 0 issues no move and raises `done` on the next cycle.
- R11: Start and all configuration inputs are ignored while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch the configuration and begin (idle only) |
| next_step | input | 1 | Resume after a group, or leave the finished state |
| vl_in | input | VLW | Vector length, 0 to VL_MAX |
| src_len_code | input | 2 | Source subvector length minus one |
| dst_len_code | input | 2 | Destination subvector length minus one |
| pack_en | input | 1 | Source walks subvector-outer |
| unpack_en | input | 1 | Destination walks subvector-outer |
| vert_first | input | 1 | Group moves, with an external step per group |
| swiz | input | 12 | Four 3-bit lane selectors |
| mv_valid | output | 1 | A move is presented this cycle |
| rd_en | output | 1 | The move reads a source element |
| wr_en | output | 1 | The move writes its destination element |
| const_valid | output | 1 | The move writes a constant |
| const_one | output | 1 | The constant is one (else zero) |
| src_idx | output | IDXW | Source element index |
| dst_idx | output | IDXW | Destination element index |
| done | output | 1 | Group or sequence finished; waiting for next_step |

## Verification
The hardest case to reach is a truncated final group in vertical-first mode. It needs VL*DST to be a non-multiple of the group size, combined with the order flag that sets that group size. The stimulus uses unpack-only with a source length of 4 and a total of 6 moves, which gives groups of 4 and 2. A second hard case is a start pulse with altered configuration that arrives while moves are running. The driver injects that pulse in the middle of a run, and the scoreboard expects the original sequence without change.

// File: rtl/swz_seq_pkg.sv
package swz_seq_pkg;

    localparam int LANES = 4;
    localparam int SELW  = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MOVE,
        ST_PAUSE,
        ST_FINI
    } seq_state_e;

    typedef enum logic [2:0] {
        SEL_SKIP = 3'd0,
        SEL_ZERO = 3'd1,
        SEL_ONE  = 3'd2,
        SEL_X    = 3'd3,
        SEL_Y    = 3'd4,
        SEL_Z    = 3'd5,
        SEL_W    = 3'd6,
        SEL_RSVD = 3'd7
    } sel_code_e;

    typedef struct packed {
        logic pack;
        logic unpack;
        logic vf;
    } walk_mode_t;

endpackage

// File: rtl/swz_lane_pick.sv
module swz_lane_pick
    import swz_seq_pkg::*;
(
    input  logic [LANES*SELW-1:0] swiz,
    input  logic [1:0]            pos,
    input  logic [2:0]            src_len,
    output logic [1:0]            lane,
    output logic                  rd,
    output logic                  wr,
    output logic                  cv,
    output logic                  c1
);

    logic [SELW-1:0] sel_arr [LANES];
    logic [SELW-1:0] sel;
    logic            lane_ok;

    for (genvar k = 0; k < LANES; k++) begin : g_split
        assign sel_arr[k] = swiz[k*SELW +: SELW];
    end

    assign sel     = sel_arr[pos];
    assign lane    = sel[1:0] + 2'd1;
    assign lane_ok = ({1'b0, lane} < src_len);

    always_comb begin
        rd = 1'b0;
        wr = 1'b0;
        cv = 1'b0;
        c1 = 1'b0;
        unique case (sel_code_e'(sel))
            SEL_SKIP, SEL_RSVD: ;
            SEL_ZERO: begin
                wr = 1'b1;
                cv = 1'b1;
            end
            SEL_ONE: begin
                wr = 1'b1;
                cv = 1'b1;
                c1 = 1'b1;
            end
            SEL_X, SEL_Y, SEL_Z, SEL_W: begin
                rd = lane_ok;
                wr = lane_ok;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/swz_idx_map.sv
module swz_idx_map #(
    parameter int VLW  = 5,
    parameter int IDXW = 6
) (
    input  logic [VLW-1:0]  elem,
    input  logic [1:0]      pos,
    input  logic [VLW-1:0]  vl,
    input  logic [2:0]      len,
    input  logic            outer,
    output logic [IDXW-1:0] idx
);

    always_comb begin
        if (outer)
            idx = IDXW'(pos) * IDXW'(vl) + IDXW'(elem);
        else
            idx = IDXW'(elem) * IDXW'(len) + IDXW'(pos);
    end

endmodule

// File: rtl/swz_seq_fsm.sv
module swz_seq_fsm
    import swz_seq_pkg::*;
#(
    parameter int VLW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           vl_zero,
    input  logic           next_step,
    input  logic [VLW-1:0] vl,
    input  logic [2:0]     dst_len,
    input  logic [2:0]     grp_size,
    input  walk_mode_t     mode,
    output logic           mv_valid,
    output logic           done,
    output logic           idle,
    output logic [VLW-1:0] elem,
    output logic [1:0]     pos
);

    seq_state_e     state_q, state_d;
    logic [VLW-1:0] elem_q;
    logic [1:0]     pos_q;
    logic [2:0]     grp_q;
    logic           elem_end, pos_end, last, grp_end;

    assign elem_end = (elem_q == vl - VLW'(1));
    assign pos_end  = ({1'b0, pos_q} == dst_len - 3'd1);
    assign last     = elem_end && pos_end;
    assign grp_end  = (grp_q == grp_size - 3'd1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = vl_zero ? ST_FINI : ST_MOVE;
            ST_MOVE: begin
                if (last)                     state_d = ST_FINI;
                else if (mode.vf && grp_end)  state_d = ST_PAUSE;
            end
            ST_PAUSE: if (next_step) state_d = ST_MOVE;
            ST_FINI:  if (next_step) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            elem_q  <= '0;
            pos_q   <= '0;
            grp_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                elem_q <= '0;
                pos_q  <= '0;
                grp_q  <= '0;
            end else if (state_q == ST_MOVE) begin
                grp_q <= grp_end ? 3'd0 : grp_q + 3'd1;
                if (mode.unpack) begin
                    if (elem_end) begin
                        elem_q <= '0;
                        pos_q  <= pos_q + 2'd1;
                    end else begin
                        elem_q <= elem_q + VLW'(1);
                    end
                end else begin
                    if (pos_end) begin
                        pos_q  <= '0;
                        elem_q <= elem_q + VLW'(1);
                    end else begin
                        pos_q <= pos_q + 2'd1;
                    end
                end
            end
        end
    end

    always_comb begin
        mv_valid = (state_q == ST_MOVE);
        done     = (state_q == ST_PAUSE) || (state_q == ST_FINI);
        idle     = (state_q == ST_IDLE);
        elem     = elem_q;
        pos      = pos_q;
    end

    // R8: a move and the done indication never coincide
    p_valid_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mv_valid && done));

    // R8: a start with non-zero length produces a move on the next cycle
    p_start_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && !vl_zero) |=> mv_valid);

    // R10: a zero length goes straight to done
    p_vl_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && vl_zero) |=> (done && !mv_valid));

    // R9: a pause resumes moving on the external step
    p_pause_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE && next_step) |=> mv_valid);

endmodule

// File: rtl/swz_pu_seq.sv
module swz_pu_seq
    import swz_seq_pkg::*;
#(
    parameter int VL_MAX = 16,
    localparam int VLW   = $clog2(VL_MAX + 1),
    localparam int IDXW  = $clog2(VL_MAX * LANES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  next_step,
    input  logic [VLW-1:0]        vl_in,
    input  logic [1:0]            src_len_code,
    input  logic [1:0]            dst_len_code,
    input  logic                  pack_en,
    input  logic                  unpack_en,
    input  logic                  vert_first,
    input  logic [LANES*SELW-1:0] swiz,
    output logic                  mv_valid,
    output logic                  rd_en,
    output logic                  wr_en,
    output logic                  const_valid,
    output logic                  const_one,
    output logic [IDXW-1:0]       src_idx,
    output logic [IDXW-1:0]       dst_idx,
    output logic                  done
);

    logic [VLW-1:0]        vl_q;
    logic [2:0]            src_len_q, dst_len_q;
    walk_mode_t            mode_q;
    logic [LANES*SELW-1:0] swiz_q;

    logic                  idle, fsm_valid, fsm_done;
    logic [VLW-1:0]        elem;
    logic [1:0]            pos, lane;
    logic                  p_rd, p_wr, p_cv, p_c1;
    logic [IDXW-1:0]       s_idx, d_idx;
    logic [2:0]            grp_size;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q      <= '0;
            src_len_q <= 3'd1;
            dst_len_q <= 3'd1;
            mode_q    <= '0;
            swiz_q    <= '0;
        end else if (idle && start) begin
            vl_q      <= vl_in;
            src_len_q <= {1'b0, src_len_code} + 3'd1;
            dst_len_q <= {1'b0, dst_len_code} + 3'd1;
            mode_q    <= '{pack: pack_en, unpack: unpack_en, vf: vert_first};
            swiz_q    <= swiz;
        end
    end

    always_comb begin
        if (mode_q.pack && mode_q.unpack) grp_size = 3'd1;
        else if (mode_q.pack)             grp_size = dst_len_q;
        else                              grp_size = src_len_q;
    end

    swz_seq_fsm #(.VLW(VLW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .vl_zero   (vl_in == '0),
        .next_step (next_step),
        .vl        (vl_q),
        .dst_len   (dst_len_q),
        .grp_size  (grp_size),
        .mode      (mode_q),
        .mv_valid  (fsm_valid),
        .done      (fsm_done),
        .idle      (idle),
        .elem      (elem),
        .pos       (pos)
    );

    swz_lane_pick u_pick (
        .swiz    (swiz_q),
        .pos     (pos),
        .src_len (src_len_q),
        .lane    (lane),
        .rd      (p_rd),
        .wr      (p_wr),
        .cv      (p_cv),
        .c1      (p_c1)
    );

    swz_idx_map #(.VLW(VLW), .IDXW(IDXW)) u_src_map (
        .elem  (elem),
        .pos   (lane),
        .vl    (vl_q),
        .len   (src_len_q),
        .outer (mode_q.pack),
        .idx   (s_idx)
    );

    swz_idx_map #(.VLW(VLW), .IDXW(IDXW)) u_dst_map (
        .elem  (elem),
        .pos   (pos),
        .vl    (vl_q),
        .len   (dst_len_q),
        .outer (mode_q.unpack),
        .idx   (d_idx)
    );

    always_comb begin
        mv_valid    = fsm_valid;
        done        = fsm_done;
        rd_en       = fsm_valid && p_rd;
        wr_en       = fsm_valid && p_wr;
        const_valid = fsm_valid && p_cv;
        const_one   = fsm_valid && p_c1;
        src_idx     = (fsm_valid && p_rd) ? s_idx : '0;
        dst_idx     = fsm_valid ? d_idx : '0;
    end

    // R2: destination index stays inside the destination vector
    p_dst_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid |-> (int'(dst_idx) < int'(vl_q) * int'(dst_len_q)));

    // R6: a read and a constant never coincide
    p_rd_const_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && const_valid));

    // R6: writes only happen inside a move
    p_wr_needs_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> mv_valid);

    // R11: configuration is frozen while not idle
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> ($stable(vl_q) && $stable(swiz_q) && $stable(mode_q)));

endmodule

// File: tb/test_swz_pu_seq.sv
`timescale 1ns/1ps
module test_swz_pu_seq;

    localparam int VL_MAX = 16;
    localparam int VLW    = $clog2(VL_MAX + 1);
    localparam int IDXW   = $clog2(VL_MAX * 4);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            next_step = 1'b0;
    logic [VLW-1:0]  vl_in = '0;
    logic [1:0]      src_len_code = '0;
    logic [1:0]      dst_len_code = '0;
    logic            pack_en = 1'b0;
    logic            unpack_en = 1'b0;
    logic            vert_first = 1'b0;
    logic [11:0]     swiz = '0;
    logic            mv_valid, rd_en, wr_en, const_valid, const_one, done;
    logic [IDXW-1:0] src_idx, dst_idx;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit    is_done;
        bit    wr, rd, cv, c1;
        int    src, dst;
        string req;
    } exp_t;

    exp_t exp_q[$];
    bit   done_prev = 1'b0;

    always #2.5 clk = ~clk;

    swz_pu_seq #(.VL_MAX(VL_MAX)) i_swz_pu_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .next_step(next_step),
        .vl_in(vl_in), .src_len_code(src_len_code), .dst_len_code(dst_len_code),
        .pack_en(pack_en), .unpack_en(unpack_en), .vert_first(vert_first),
        .swiz(swiz), .mv_valid(mv_valid), .rd_en(rd_en), .wr_en(wr_en),
        .const_valid(const_valid), .const_one(const_one),
        .src_idx(src_idx), .dst_idx(dst_idx), .done(done)
    );

    // monitor: compares each observed move or done edge with the queue head
    always @(negedge clk) begin
        exp_t it;
        if (rst_n) begin
            if (mv_valid || (done && !done_prev)) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R8 unexpected output: actual valid=%0b done=%0b expected nothing",
                             mv_valid, done);
                end else begin
                    it = exp_q.pop_front();
                    if (it.is_done) begin
                        if (!(done && !mv_valid)) begin
                            fails++;
                            $display("FAIL %s done: actual valid=%0b done=%0b expected done",
                                     it.req, mv_valid, done);
                        end
                    end else if (!mv_valid || wr_en != it.wr || rd_en != it.rd ||
                                 const_valid != it.cv || const_one != it.c1 ||
                                 int'(src_idx) != it.src || int'(dst_idx) != it.dst) begin
                        fails++;
                        $display("FAIL %s move: actual v=%0b w=%0b r=%0b cv=%0b c1=%0b src=%0d dst=%0d expected w=%0b r=%0b cv=%0b c1=%0b src=%0d dst=%0d",
                                 it.req, mv_valid, wr_en, rd_en, const_valid, const_one,
                                 src_idx, dst_idx, it.wr, it.rd, it.cv, it.c1, it.src, it.dst);
                    end
                end
            end
            done_prev = done;
        end
    end

    // driver: builds the expected sequence, then runs the handshake
    task automatic run(input int vl, input int sl, input int dl, input bit pk,
                       input bit up, input bit vf, input logic [11:0] sw,
                       input bit poke, input string req);
        int total, grp, n, ngroups;
        total = vl * dl;
        if (!vf)          grp = total;
        else if (pk && up) grp = 1;
        else if (pk)      grp = dl;
        else              grp = sl;
        n = 0;
        ngroups = 1;
        if (vl == 0) begin
            exp_q.push_back('{1'b1, 0, 0, 0, 0, 0, 0, req});
        end else begin
            ngroups = vf ? (total + grp - 1) / grp : 1;
            for (int o = 0; o < (up ? dl : vl); o++) begin
                for (int q = 0; q < (up ? vl : dl); q++) begin
                    exp_t e;
                    int i, j, sel, lane;
                    i = up ? q : o;
                    j = up ? o : q;
                    sel = int'(sw[3*j +: 3]);
                    e = '{1'b0, 0, 0, 0, 0, 0, 0, req};
                    e.dst = up ? j * vl + i : i * dl + j;
                    if (sel == 1 || sel == 2) begin
                        e.wr = 1; e.cv = 1; e.c1 = (sel == 2);
                    end else if (sel >= 3 && sel <= 6) begin
                        lane = sel - 3;
                        if (lane < sl) begin
                            e.wr = 1; e.rd = 1;
                            e.src = pk ? lane * vl + i : i * sl + lane;
                        end
                    end
                    exp_q.push_back(e);
                    n++;
                    if ((vf && (n % grp == 0)) || n == total)
                        exp_q.push_back('{1'b1, 0, 0, 0, 0, 0, 0, req});
                end
            end
        end
        @(negedge clk);
        vl_in = VLW'(vl); src_len_code = 2'(sl - 1); dst_len_code = 2'(dl - 1);
        pack_en = pk; unpack_en = up; vert_first = vf; swiz = sw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11: restart attempt with different settings mid-run
            @(negedge clk);
            start = 1'b1; vl_in = VLW'(1); pack_en = ~pk; unpack_en = ~up;
            vert_first = 1'b1; swiz = 12'h000;
            @(negedge clk);
            start = 1'b0;
        end
        for (int g = 0; g < ngroups; g++) begin
            do @(negedge clk); while (!done);
            next_step = 1'b1;
            @(negedge clk);
            next_step = 1'b0;
        end
        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0 || mv_valid || done) begin
            fails++;
            $display("FAIL %s leftover: actual pending=%0d valid=%0b done=%0b expected 0 0 0",
                     req, exp_q.size(), mv_valid, done);
            exp_q.delete();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;   // R1 reset state
        if (mv_valid || wr_en || done) begin
            fails++;
            $display("FAIL R1 reset: actual valid=%0b wr=%0b done=%0b expected 0 0 0",
                     mv_valid, wr_en, done);
        end
        // R2: vec3 -> vec2, lanes Z then Y
        run(3, 3, 2, 0, 0, 0, {3'd0, 3'd0, 3'd4, 3'd5}, 0, "R2");
        // R3: pack, vec2 -> vec4 as Y Y X X
        run(4, 2, 4, 1, 0, 0, {3'd3, 3'd3, 3'd4, 3'd4}, 0, "R3");
        // R4: unpack, X W one
        run(3, 4, 3, 0, 1, 0, {3'd0, 3'd2, 3'd6, 3'd3}, 0, "R4");
        // R5: both flags, horizontal
        run(3, 2, 2, 1, 1, 0, {3'd0, 3'd0, 3'd3, 3'd4}, 0, "R5");
        // R6 and R7: skip, zero, reserved, out-of-range Z
        run(2, 2, 4, 0, 0, 0, {3'd5, 3'd7, 3'd1, 3'd0}, 0, "R6_R7");
        run(2, 3, 3, 0, 0, 0, {3'd0, 3'd2, 3'd6, 3'd5}, 0, "R7");
        // R9: vertical-first default, pack, both, truncated unpack
        run(3, 3, 2, 0, 0, 1, {3'd0, 3'd0, 3'd3, 3'd5}, 0, "R9");
        run(3, 2, 4, 1, 0, 1, {3'd4, 3'd3, 3'd2, 3'd4}, 0, "R9");
        run(2, 2, 2, 1, 1, 1, {3'd0, 3'd0, 3'd3, 3'd4}, 0, "R9_R5");
        run(3, 4, 2, 0, 1, 1, {3'd0, 3'd0, 3'd6, 3'd3}, 0, "R9");
        // R10: zero length
        run(0, 2, 2, 0, 0, 0, 12'h0e3, 0, "R10");
        // R11: start pulse mid-run ignored
        run(4, 2, 2, 0, 0, 0, {3'd0, 3'd0, 3'd3, 3'd4}, 1, "R11");
        // R8: full-length horizontal
        run(16, 4, 4, 0, 0, 0, {3'd6, 3'd5, 3'd4, 3'd3}, 0, "R8");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule